// File: doc/BRIEF.md
# Bidirectional Busy Line Relay with Phase-Selected Filter

This block carries the bus busy signal between two bus segments, side A and side B. Whichever side asserts busy first becomes the source, and the block pulls the other side low through an open-collector style enable. It never drives either line high. Each side's receiver sees the whole wire, so the block hears its own drive coming back. While the block is pulling a side, that side's received level is ignored as an input. This stops the relay from latching itself on.

Each direction has the same chain. First an echo mask, then a leading-edge debounce, then a second stage with two run-time behaviours. A new assertion is taken at once and then held for a fixed minimum number of cycles, so contact-style bounce cannot chop it up. After that hold the debounced level follows the input. In the second stage, the direct setting passes the debounced level on after one register. The long setting only lets the output change once the debounced level has held a new value for an extended window. An external bus-phase tracker selects the long setting in phases where the busy and select drivers may move from one side to the other.

Top module: `busy_relay`

## Requirements
- R1: While reset is low, and on the first cycle after it, both pull-down enables are low.
- R2: With neither side asserting busy, both pull-down enables stay low.
- R3: In direct mode, an assertion on side A raises the side B enable on the second clock edge after the assertion is first sampled. It is still low after the first edge.
- R4: In direct mode, an assertion on side B raises the side A enable with the same two-edge latency, and the side B enable stays low.
- R5: While the block pulls a side low, the echo received on that side does not start propagation back the other way. The enable of the source side stays low.
- R6: An assertion lasting a single cycle keeps the far-side enable high for exactly HOLD_CYC cycles (default 4) in direct mode.
- R7: Once the hold time has passed, release of the source side drops the far-side enable on the second clock edge after the release is sampled.
- R8: With long_filter_en high (long mode), the far-side enable changes only after the debounced level has held its new value through STABLE_CYC edges (default 32). For a clean assertion or release this is edge STABLE_CYC+1 after the input change.
- R9: In long mode, any return of the debounced level to the current output value restarts the stability count. A release shorter than STABLE_CYC cycles followed by a reassertion leaves the enable high, and a later release needs the full window again.
- R10: Lowering long_filter_en takes effect on the next clock edge, and the output then follows the debounced level directly. The long-mode count is cleared, so a return to long mode again needs the full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_a_rx | input | 1 | Received busy level on side A, 1 = asserted |
| bus_b_rx | input | 1 | Received busy level on side B, 1 = asserted |
| long_filter_en | input | 1 | Phase indication: 1 selects long stability filter, 0 direct pass |
| pull_a_en | output | 1 | Pull-down enable for side A, 1 = pull line to asserted |
| pull_b_en | output | 1 | Pull-down enable for side B, 1 = pull line to asserted |

## Verification
The bench models the wired bus: each received line is the external driver ORed with the block's own enable for that side, so every echo is present.

Directed patterns cover the cases that separate the behaviours:
- A long assertion from each side in turn tells the two directions apart and exposes any echo lock-up.
- A one-cycle glitch measures the hold width.
- Long-mode assertion and release, including a short release followed by reassertion, separate a stability count that restarts from one that only accumulates.
- A mode drop in the middle of a window shows whether the switch lands on the next edge.

Seeded random segments then mix idle spans, runs from either side, contention, short glitches and mode flips. Each cycle is compared against a bench model of the requirements.

// File: rtl/busy_relay_pkg.sv
// Package: busy_relay_pkg
// Shared types for the busy line relay. Holds the second-stage mode
// encoding and the side count of the relay.
package busy_relay_pkg;

    // Number of bus sides the relay joins; one channel per source side.
    localparam int unsigned NUM_SIDES = 2;

    // Second-stage behaviour, selected by the bus-phase indication.
    typedef enum logic {
        FILT_PASS = 1'b0,   // debounced level goes straight out
        FILT_LONG = 1'b1    // output moves only after a long stable window
    } filt_mode_e;

endpackage : busy_relay_pkg

// File: rtl/busy_echo_mask.sv
// Module: busy_echo_mask
// Turns a received busy level into a source request. The level is
// blanked while this relay is itself pulling the same side low.
// Assumes: own_pull_i is the registered enable for the side that
// rx_i is received from, so the mask has no combinational loop.
module busy_echo_mask (
    input  logic rx_i,
    input  logic own_pull_i,
    output logic src_o
);

    // Blank the received level while our own drive is on that wire.
    always_comb begin
        src_o = rx_i & ~own_pull_i;
    end

endmodule : busy_echo_mask

// File: rtl/busy_debounce.sv
// Module: busy_debounce
// Leading-edge debounce. A rising request is taken on the next edge
// and then held high for at least HOLD_CYC cycles. After that the
// output follows the request.
// Assumes: HOLD_CYC >= 1; src_i is synchronous to clk.
module busy_debounce #(
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    output logic deb_o
);

    localparam int unsigned HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [HW-1:0] HLOAD = HW'(HOLD_CYC - 1);

    logic [HW-1:0] hold_cnt_q;
    logic          deb_q;

    // Capture the leading edge, run out the hold, then track the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deb_q      <= 1'b0;
            hold_cnt_q <= '0;
        end else if (!deb_q) begin
            if (src_i) begin
                deb_q      <= 1'b1;
                hold_cnt_q <= HLOAD;
            end
        end else if (hold_cnt_q != '0) begin
            hold_cnt_q <= hold_cnt_q - HW'(1);
        end else begin
            deb_q <= src_i;
        end
    end

    assign deb_o = deb_q;

endmodule : busy_debounce

// File: rtl/busy_mode_filter.sv
// Module: busy_mode_filter
// Second stage of a busy channel. In pass mode the output copies the
// debounced level each edge. In long mode it changes only after the
// debounced level has differed from it for STABLE_CYC edges in a row.
// Assumes: STABLE_CYC >= 2; mode_i is synchronous to clk.
module busy_mode_filter
    import busy_relay_pkg::*;
#(
    parameter int unsigned STABLE_CYC = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  filt_mode_e mode_i,
    input  logic       deb_i,
    output logic       out_o
);

    localparam int unsigned SW = (STABLE_CYC > 2) ? $clog2(STABLE_CYC) : 1;
    localparam logic [SW-1:0] SLAST = SW'(STABLE_CYC - 1);

    logic [SW-1:0] stab_cnt_q;
    logic          out_q;

    // Pass or count stability, clearing the count whenever it is moot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q      <= 1'b0;
            stab_cnt_q <= '0;
        end else if (mode_i == FILT_PASS) begin
            out_q      <= deb_i;
            stab_cnt_q <= '0;
        end else if (deb_i == out_q) begin
            stab_cnt_q <= '0;
        end else if (stab_cnt_q == SLAST) begin
            out_q      <= deb_i;
            stab_cnt_q <= '0;
        end else begin
            stab_cnt_q <= stab_cnt_q + SW'(1);
        end
    end

    assign out_o = out_q;

endmodule : busy_mode_filter

// File: rtl/busy_relay.sv
// Module: busy_relay
// Two-sided busy line relay. Channel d takes side d as its source
// and drives the pull-down on the opposite side. The echo of a side
// this relay is pulling is masked out of that side's channel.
// Assumes: received levels are already synchronized to clk and are
// active high; outputs go to open-collector pull-down drivers.
module busy_relay
    import busy_relay_pkg::*;
#(
    parameter int unsigned HOLD_CYC   = 4,
    parameter int unsigned STABLE_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_a_rx,
    input  logic bus_b_rx,
    input  logic long_filter_en,
    output logic pull_a_en,
    output logic pull_b_en
);

    logic [NUM_SIDES-1:0] rx_v;
    logic [NUM_SIDES-1:0] src_v;
    logic [NUM_SIDES-1:0] deb_v;
    logic [NUM_SIDES-1:0] out_v;
    logic [NUM_SIDES-1:0] pull_v;
    filt_mode_e           mode_sel;

    // Gather the received sides and the phase-selected mode.
    always_comb begin
        rx_v     = {bus_b_rx, bus_a_rx};
        mode_sel = filt_mode_e'(long_filter_en);
    end

    // Each side is pulled by the channel sourced from the other side.
    always_comb begin
        for (int s = 0; s < int'(NUM_SIDES); s++) begin
            pull_v[s] = out_v[NUM_SIDES-1-s];
        end
    end

    for (genvar d = 0; d < NUM_SIDES; d++) begin : g_chan
        busy_echo_mask u_mask (
            .rx_i       (rx_v[d]),
            .own_pull_i (pull_v[d]),
            .src_o      (src_v[d])
        );

        busy_debounce #(
            .HOLD_CYC (HOLD_CYC)
        ) u_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .src_i (src_v[d]),
            .deb_o (deb_v[d])
        );

        busy_mode_filter #(
            .STABLE_CYC (STABLE_CYC)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (mode_sel),
            .deb_i  (deb_v[d]),
            .out_o  (out_v[d])
        );
    end

    assign pull_a_en = pull_v[0];
    assign pull_b_en = pull_v[1];

endmodule : busy_relay

// File: rtl/busy_relay_checker.sv
// Module: busy_relay_checker
// Temporal checks on the relay's stages. Bound into busy_relay.
// Assumes: deb_v/out_v are the per-channel debounce and filter outputs.
module busy_relay_checker #(
    parameter int unsigned HOLD_CYC   = 4,
    parameter int unsigned STABLE_CYC = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       long_filter_en,
    input logic [1:0] deb_v,
    input logic [1:0] out_v,
    input logic       pull_a_en,
    input logic       pull_b_en
);

    localparam int unsigned RW   = $clog2(HOLD_CYC + STABLE_CYC + 2);
    localparam logic [RW-1:0] RMAX = RW'(HOLD_CYC + STABLE_CYC + 1);

    logic [1:0] pull_side;
    assign pull_side = {pull_b_en, pull_a_en};

    for (genvar d = 0; d < 2; d++) begin : g_chk
        logic [RW-1:0] run_q;
        logic          prev_q;

        // Count edges for which the debounced level has been unchanged.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_q  <= '0;
                prev_q <= 1'b0;
            end else begin
                prev_q <= deb_v[d];
                if (deb_v[d] != prev_q) run_q <= '0;
                else if (run_q != RMAX) run_q <= run_q + RW'(1);
            end
        end

        // R5: echo of our own pull on the source side starts nothing.
        p_echo_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(pull_side[d]) && !$past(deb_v[d])) |-> !deb_v[d]);

        // R3: in direct mode the output is the debounced level one edge later.
        p_pass_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(long_filter_en) |-> (out_v[d] == $past(deb_v[d])));

        // R8: in long mode a change needs a full stable window.
        p_long_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(long_filter_en) && (out_v[d] != $past(out_v[d])))
                |-> (run_q >= RW'(STABLE_CYC - 1)));

        // R8: a long-mode change moves to the debounced value.
        p_long_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(long_filter_en) && (out_v[d] != $past(out_v[d])))
                |-> (out_v[d] == $past(deb_v[d])));

        // R6: the debounced level stays high at least the hold time.
        p_hold_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(deb_v[d]) |-> (run_q >= RW'(HOLD_CYC - 1)));
    end

endmodule : busy_relay_checker

bind busy_relay busy_relay_checker #(
    .HOLD_CYC   (HOLD_CYC),
    .STABLE_CYC (STABLE_CYC)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .long_filter_en (long_filter_en),
    .deb_v          (deb_v),
    .out_v          (out_v),
    .pull_a_en      (pull_a_en),
    .pull_b_en      (pull_b_en)
);

// File: tb/busy_relay_tb_top.sv
// Bench for busy_relay: wired-bus model, directed corners, then seeded
// random segments compared with a requirement model each cycle.
module busy_relay_tb_top;

    localparam int HOLD   = 4;
    localparam int STABLE = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_a = 1'b0;
    logic ext_b = 1'b0;
    logic long_en = 1'b0;
    logic pull_a_en, pull_b_en;
    logic bus_a_rx, bus_b_rx;

    int n_tests = 0;
    int n_fail  = 0;

    // Model state per channel (0: A sources, 1: B sources).
    logic m_deb [2];
    int   m_hc  [2];
    logic m_out [2];
    int   m_sc  [2];

    always #5 clk = ~clk;

    // Wired bus: a line reads asserted if anyone pulls it.
    assign bus_a_rx = ext_a | pull_a_en;
    assign bus_b_rx = ext_b | pull_b_en;

    busy_relay #(.HOLD_CYC(HOLD), .STABLE_CYC(STABLE)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_a_rx       (bus_a_rx),
        .bus_b_rx       (bus_b_rx),
        .long_filter_en (long_en),
        .pull_a_en      (pull_a_en),
        .pull_b_en      (pull_b_en)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic f_src(input logic ext, input logic pulled);
        return ext & ~pulled;
    endfunction

    // Advance the requirement model and the DUT by one edge.
    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            logic src [2];
            src[0] = f_src(ext_a, m_out[1]);
            src[1] = f_src(ext_b, m_out[0]);
            @(posedge clk);
            for (int d = 0; d < 2; d++) begin
                logic dold;
                dold = m_deb[d];
                if (!rst_n) begin
                    m_deb[d] = 0; m_hc[d] = 0; m_out[d] = 0; m_sc[d] = 0;
                end else begin
                    if (!long_en) begin m_out[d] = dold; m_sc[d] = 0; end
                    else if (dold == m_out[d]) m_sc[d] = 0;
                    else if (m_sc[d] == STABLE - 1) begin m_out[d] = dold; m_sc[d] = 0; end
                    else m_sc[d]++;
                    if (!dold) begin
                        if (src[d]) begin m_deb[d] = 1; m_hc[d] = HOLD - 1; end
                    end else if (m_hc[d] != 0) m_hc[d]--;
                    else m_deb[d] = src[d];
                end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(10 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int highs;
        for (int d = 0; d < 2; d++) begin m_deb[d] = 0; m_hc[d] = 0; m_out[d] = 0; m_sc[d] = 0; end
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc(3);
        chk("R1 reset pull_a", pull_a_en, 1'b0);
        chk("R1 reset pull_b", pull_b_en, 1'b0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 first cycle after reset", pull_a_en | pull_b_en, 1'b0);
        for (int i = 0; i < 5; i++) begin
            cyc(1);
            chk("R2 idle pull_a", pull_a_en, 1'b0);
            chk("R2 idle pull_b", pull_b_en, 1'b0);
        end

        // R3 / R5 / R7: direct mode, side A source.
        ext_a = 1'b1;
        cyc(1); chk("R3 A->B after 1 edge", pull_b_en, 1'b0);
        cyc(1); chk("R3 A->B after 2 edges", pull_b_en, 1'b1);
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            chk("R5 echo on B ignored", pull_a_en, 1'b0);
        end
        ext_a = 1'b0;
        cyc(1); chk("R7 release after 1 edge", pull_b_en, 1'b1);
        cyc(1); chk("R7 release after 2 edges", pull_b_en, 1'b0);
        cyc(3);

        // R6: one-cycle glitch held for HOLD cycles.
        ext_a = 1'b1;
        cyc(1);
        ext_a = 1'b0;
        highs = 0;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            if (pull_b_en) highs++;
        end
        chk("R6 glitch hold width", highs == HOLD, 1'b1);
        if (highs != HOLD) $display("  R6 detail: highs=%0d expected=%0d", highs, HOLD);

        // R4: direct mode, side B source.
        ext_b = 1'b1;
        cyc(1); chk("R4 B->A after 1 edge", pull_a_en, 1'b0);
        cyc(1); chk("R4 B->A after 2 edges", pull_a_en, 1'b1);
        chk("R4 source side not pulled", pull_b_en, 1'b0);
        cyc(8);
        ext_b = 1'b0;
        cyc(2); chk("R4 release", pull_a_en, 1'b0);
        cyc(3);

        // R8: long mode assertion.
        long_en = 1'b1;
        cyc(2);
        ext_a = 1'b1;
        for (int i = 1; i <= STABLE + 2; i++) begin
            cyc(1);
            chk("R8 long assert timing", pull_b_en, logic'(i >= STABLE + 1));
        end

        // R9: short release then reassert, then a full release.
        ext_a = 1'b0;
        for (int i = 0; i < 20; i++) begin cyc(1); chk("R9 short release holds", pull_b_en, 1'b1); end
        ext_a = 1'b1;
        for (int i = 0; i < 5; i++) begin cyc(1); chk("R9 reassert holds", pull_b_en, 1'b1); end
        ext_a = 1'b0;
        for (int i = 1; i <= STABLE + 2; i++) begin
            cyc(1);
            chk("R9 restarted window on release", pull_b_en, logic'(i < STABLE + 1));
            chk("R5 source side quiet", pull_a_en, 1'b0);
        end
        cyc(3);

        // R10: drop to direct mode mid-window.
        ext_a = 1'b1;
        cyc(6); chk("R10 still filtering", pull_b_en, 1'b0);
        long_en = 1'b0;
        cyc(1); chk("R10 direct on next edge", pull_b_en, 1'b1);
        ext_a = 1'b0;
        cyc(2); chk("R10 direct release", pull_b_en, 1'b0);
        long_en = 1'b1;
        cyc(2);
        ext_a = 1'b1;
        for (int i = 1; i <= STABLE + 2; i++) begin
            cyc(1);
            chk("R10 full window after return", pull_b_en, logic'(i >= STABLE + 1));
        end
        ext_a = 1'b0;
        cyc(STABLE + 4);

        // Random segments against the model.
        for (int seg = 0; seg < 120; seg++) begin
            int pat, len;
            pat = int'($urandom % 5);
            len = 1 + int'($urandom % 40);
            if (($urandom % 4) == 0) long_en = ~long_en;
            ext_a = (pat == 1) || (pat == 3);
            ext_b = (pat == 2) || (pat == 3);
            for (int i = 0; i < len; i++) begin
                if (pat == 4) ext_a = (i == 0);
                cyc(1);
                chk(long_en ? "R8 random pull_b" : "R3 random pull_b", pull_b_en, m_out[0]);
                chk(long_en ? "R8 random pull_a" : "R4 random pull_a", pull_a_en, m_out[1]);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule : busy_relay_tb_top